// File: doc/BRIEF.md
# Address-Event Fan-Out Router

This block connects up to four event sources to up to four event sinks. A source presents an event as an address together with a request line. The router identifies the event by the number of the input port it arrived on and by its address. It uses that pair to look up a programmable connectivity table. The table entry points into a destination list, and the router emits one outgoing event for every word in the selected slice of that list. Each outgoing event goes to the output port and carries the output address given by the list word. Routing therefore depends only on which source talks to which sink, and the coupling pattern lives entirely in the two tables.

Every event port uses a four-phase request/acknowledge handshake. The router synchronises all incoming request and acknowledge lines with two flip-flop stages. When several inputs wait at once, they are served in rotating order. Fan-out is strictly sequential: one outgoing event at a time, in list order. The input event is acknowledged only after its last destination has completed its handshake. A host loads both tables through a write port with a ready signal. Writes land only while the router is idle, so an event in progress always sees one consistent table.

Top module: `event_fanout_router`

## Requirements
- R1: After reset, no output request and no input acknowledge is asserted, and `cfgReady` is high.
- R2: A map write (`cfgSel`=0) stores at index `{port[1:0], addr[7:0]}` the data `{ptr[9:4], cnt[3:0]}`. A list write (`cfgSel`=1) stores at slot `cfgIdx[5:0]` the data `{dstPort[9:8], dstAddr[7:0]}`. An input event on port p with address a produces exactly cnt output events, taken from list slots ptr, ptr+1, … in that order. Each of these events is raised on `outReq[dstPort]` with `dstAddr` on that port's address lane.
- R3: A map entry with a count of zero produces no output event, and its input event is still acknowledged.
- R4: An input acknowledge rises only after every destination handshake of that event has completed. No output request is high while any input acknowledge is high, and at most one input acknowledge is high at a time.
- R5: At most one output request is high at a time. Its address lane stays stable while it is high. The request falls only after its acknowledge has been seen high.
- R6: When several inputs request at once, service rotates, starting with the port after the one most recently served.
- R7: `cfgReady` is low while an event is being processed, and a write takes effect only in a cycle where `cfgWrEn` and `cfgReady` are both high. A write requested during a fan-out therefore does not alter the destinations of that fan-out, and it applies to later events.
- R8: An input acknowledge rises only while its request is high. It stays high until the request has been dropped, and then it falls.
- R9: The destination-list pointer wraps from slot 63 to slot 0 within one fan-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inReq | input | 4 | Per-source event request |
| inAddr | input | 32 | Per-source event address, 8 bits per port, port 0 in the low byte |
| inAck | output | 4 | Per-source event acknowledge |
| outReq | output | 4 | Per-sink event request |
| outAddr | output | 32 | Per-sink event address, 8 bits per port |
| outAck | input | 4 | Per-sink event acknowledge |
| cfgWrEn | input | 1 | Table write request, held until accepted |
| cfgSel | input | 1 | 0 selects the map table, 1 the destination list |
| cfgIdx | input | 10 | Table index |
| cfgData | input | 10 | Table write data |
| cfgReady | output | 1 | High when the router is idle and a write would be accepted |

## Verification
The hardest situation to reach from the ports is a table write that arrives in the middle of a fan-out and targets a list slot that the same fan-out has yet to read. If the write were accepted early, the later destination would silently change. The bench reaches this state by stalling the acknowledge of the first destination for many cycles. It then requests a rewrite of the second slot while the router is stalled. The bench expects the old word on that event and the new word on the next event that uses the entry. The rotation order is forced in a similar way: one port is served alone first, and then all four inputs are raised in the same cycle.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;

  typedef struct packed {
    logic grant;
    logic loadEntry;
    logic emitSet;
    logic emitClr;
    logic advance;
    logic ackSet;
    logic ackClr;
  } ctrlStrobes_t;

  typedef struct packed {
    logic anyPending;
    logic entryZero;
    logic lastDest;
    logic dstAck;
    logic srcReq;
  } dpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SEND, ST_WAITACK, ST_WAITREL, ST_ACKIN, ST_DROP
  } rtrState_t;

endpackage

// File: rtl/evt_router_sync.sv
module evt_router_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/evt_router_ctrl.sv
module evt_router_ctrl
  import evt_router_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobe,
  output logic         idle
);
  rtrState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (status.anyPending) begin
        strobe.grant = 1'b1;
        stateD = ST_FETCH;
      end
      ST_FETCH: begin
        strobe.loadEntry = 1'b1;
        stateD = status.entryZero ? ST_ACKIN : ST_SEND;
      end
      ST_SEND: begin
        strobe.emitSet = 1'b1;
        stateD = ST_WAITACK;
      end
      ST_WAITACK: if (status.dstAck) begin
        strobe.emitClr = 1'b1;
        stateD = ST_WAITREL;
      end
      ST_WAITREL: if (!status.dstAck) begin
        strobe.advance = 1'b1;
        stateD = status.lastDest ? ST_ACKIN : ST_SEND;
      end
      ST_ACKIN: begin
        strobe.ackSet = 1'b1;
        stateD = ST_DROP;
      end
      ST_DROP: if (!status.srcReq) begin
        strobe.ackClr = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign idle = (stateQ == ST_IDLE);
endmodule

// File: rtl/evt_router_dp.sv
module evt_router_dp
  import evt_router_pkg::*;
#(
  parameter int NUM_IN     = 4,
  parameter int NUM_OUT    = 4,
  parameter int ADDR_W     = 8,
  parameter int LIST_DEPTH = 64,
  parameter int CNT_W      = 4,
  parameter int CFG_IDX_W  = 10,
  parameter int CFG_DATA_W = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobe,
  output dpStatus_t                 status,
  input  logic [NUM_IN-1:0]         reqSync,
  input  logic [NUM_IN*ADDR_W-1:0]  inAddr,
  output logic [NUM_IN-1:0]         inAck,
  output logic [NUM_OUT-1:0]        outReq,
  output logic [NUM_OUT*ADDR_W-1:0] outAddr,
  input  logic [NUM_OUT-1:0]        ackSync,
  input  logic                      cfgWe,
  input  logic                      cfgSel,
  input  logic [CFG_IDX_W-1:0]      cfgIdx,
  input  logic [CFG_DATA_W-1:0]     cfgData
);
  localparam int IN_W      = $clog2(NUM_IN);
  localparam int OUT_W     = $clog2(NUM_OUT);
  localparam int LIST_W    = $clog2(LIST_DEPTH);
  localparam int MAP_W     = IN_W + ADDR_W;
  localparam int MAP_DEPTH = 1 << MAP_W;
  localparam int ENTRY_W   = LIST_W + CNT_W;
  localparam int DEST_W    = OUT_W + ADDR_W;

  logic [ENTRY_W-1:0] mapMem  [MAP_DEPTH];
  logic [DEST_W-1:0]  destMem [LIST_DEPTH];

  always_ff @(posedge clk) begin
    if (cfgWe) begin
      if (cfgSel) destMem[cfgIdx[LIST_W-1:0]] <= cfgData[DEST_W-1:0];
      else        mapMem[cfgIdx[MAP_W-1:0]]   <= cfgData[ENTRY_W-1:0];
    end
  end

  logic [IN_W-1:0]   curPort, lastGrant, pickPort;
  logic [ADDR_W-1:0] curAddr;
  logic [LIST_W-1:0] ptrQ;
  logic [CNT_W-1:0]  remainQ;
  logic [OUT_W-1:0]  curDst;
  logic [NUM_IN-1:0] pending;

  assign pending = reqSync & ~inAck;

  // rotating priority: the search starts one past the last grant
  always_comb begin
    logic found;
    found    = 1'b0;
    pickPort = '0;
    for (int k = 1; k <= NUM_IN; k++) begin
      int cand;
      cand = (int'(lastGrant) + k) % NUM_IN;
      if (!found && pending[IN_W'(cand)]) begin
        found    = 1'b1;
        pickPort = IN_W'(cand);
      end
    end
  end

  logic [ENTRY_W-1:0] entry;
  logic [DEST_W-1:0]  destWord;
  logic [OUT_W-1:0]   dstPort;
  logic [ADDR_W-1:0]  dstAddr;

  assign entry    = mapMem[{curPort, curAddr}];
  assign destWord = destMem[ptrQ];
  assign dstPort  = destWord[DEST_W-1 -: OUT_W];
  assign dstAddr  = destWord[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPort   <= '0;
      lastGrant <= IN_W'(NUM_IN - 1);
      curAddr   <= '0;
      ptrQ      <= '0;
      remainQ   <= '0;
      curDst    <= '0;
      outReq    <= '0;
      outAddr   <= '0;
      inAck     <= '0;
    end else begin
      if (strobe.grant) begin
        curPort   <= pickPort;
        lastGrant <= pickPort;
        curAddr   <= inAddr[pickPort*ADDR_W +: ADDR_W];
      end
      if (strobe.loadEntry) begin
        ptrQ    <= entry[ENTRY_W-1 -: LIST_W];
        remainQ <= entry[CNT_W-1:0];
      end
      if (strobe.emitSet) begin
        outReq[dstPort]                    <= 1'b1;
        outAddr[dstPort*ADDR_W +: ADDR_W]  <= dstAddr;
        curDst                             <= dstPort;
      end
      if (strobe.emitClr) outReq[curDst] <= 1'b0;
      if (strobe.advance) begin
        ptrQ    <= ptrQ + LIST_W'(1);
        remainQ <= remainQ - CNT_W'(1);
      end
      if (strobe.ackSet) inAck[curPort] <= 1'b1;
      if (strobe.ackClr) inAck[curPort] <= 1'b0;
    end
  end

  assign status.anyPending = |pending;
  assign status.entryZero  = (entry[CNT_W-1:0] == '0);
  assign status.lastDest   = (remainQ == CNT_W'(1));
  assign status.dstAck     = ackSync[curDst];
  assign status.srcReq     = reqSync[curPort];
endmodule

// File: rtl/event_fanout_router.sv
module event_fanout_router
  import evt_router_pkg::*;
#(
  parameter int NUM_IN     = 4,
  parameter int NUM_OUT    = 4,
  parameter int ADDR_W     = 8,
  parameter int LIST_DEPTH = 64,
  parameter int CNT_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int MAP_W      = $clog2(NUM_IN) + ADDR_W,
  localparam int LIST_W     = $clog2(LIST_DEPTH),
  localparam int ENTRY_W    = LIST_W + CNT_W,
  localparam int DEST_W     = $clog2(NUM_OUT) + ADDR_W,
  localparam int CFG_IDX_W  = (MAP_W > LIST_W) ? MAP_W : LIST_W,
  localparam int CFG_DATA_W = (ENTRY_W > DEST_W) ? ENTRY_W : DEST_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IN-1:0]         inReq,
  input  logic [NUM_IN*ADDR_W-1:0]  inAddr,
  output logic [NUM_IN-1:0]         inAck,
  output logic [NUM_OUT-1:0]        outReq,
  output logic [NUM_OUT*ADDR_W-1:0] outAddr,
  input  logic [NUM_OUT-1:0]        outAck,
  input  logic                      cfgWrEn,
  input  logic                      cfgSel,
  input  logic [CFG_IDX_W-1:0]      cfgIdx,
  input  logic [CFG_DATA_W-1:0]     cfgData,
  output logic                      cfgReady
);
  logic [NUM_IN-1:0]  reqSync;
  logic [NUM_OUT-1:0] ackSync;
  ctrlStrobes_t       strobe;
  dpStatus_t          status;
  logic               idle;

  evt_router_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) reqSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(inReq), .syncOut(reqSync));

  evt_router_sync #(.WIDTH(NUM_OUT), .STAGES(SYNC_STAGES)) ackSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(outAck), .syncOut(ackSync));

  evt_router_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .status(status), .strobe(strobe), .idle(idle));

  evt_router_dp #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W),
    .LIST_DEPTH(LIST_DEPTH), .CNT_W(CNT_W),
    .CFG_IDX_W(CFG_IDX_W), .CFG_DATA_W(CFG_DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .reqSync(reqSync), .inAddr(inAddr), .inAck(inAck),
    .outReq(outReq), .outAddr(outAddr), .ackSync(ackSync),
    .cfgWe(cfgWrEn & idle), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgData(cfgData));

  assign cfgReady = idle;
endmodule

// File: rtl/evt_router_chk.sv
module evt_router_chk #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int ADDR_W  = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_IN-1:0]         inReq,
  input logic [NUM_IN-1:0]         inAck,
  input logic [NUM_OUT-1:0]        outReq,
  input logic [NUM_OUT*ADDR_W-1:0] outAddr,
  input logic [NUM_OUT-1:0]        outAck,
  input logic                      cfgReady
);
  // R5
  one_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outReq));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~outReq & $past(outReq) & ~$past(outAck)) == '0));

  // R5
  out_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq != '0 && outReq == $past(outReq)) |-> $stable(outAddr));

  // R4
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inAck != '0) |-> (outReq == '0));

  // R4
  one_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inAck));

  // R8
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((inAck & ~$past(inAck) & ~$past(inReq)) == '0));

  // R8
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~inAck & $past(inAck) & $past(inReq)) == '0));

  // R7
  busy_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq != '0) |-> !cfgReady);
endmodule

bind event_fanout_router evt_router_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .inReq(inReq), .inAck(inAck),
  .outReq(outReq), .outAddr(outAddr), .outAck(outAck), .cfgReady(cfgReady));

// File: tb/event_fanout_router_tb_top.sv
module event_fanout_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  inReq = '0;
  logic [31:0] inAddr;
  logic [3:0]  inAck;
  logic [3:0]  outReq;
  logic [31:0] outAddr;
  logic [3:0]  outAck = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [9:0]  cfgIdx = '0;
  logic [9:0]  cfgData = '0;
  logic        cfgReady;

  logic [7:0]  addrReg [4];
  logic [9:0]  mapSh   [1024];
  logic [9:0]  listSh  [64];
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign inAddr = {addrReg[3], addrReg[2], addrReg[1], addrReg[0]};

  event_fanout_router dut_i (
    .clk(clk), .rstN(rstN), .inReq(inReq), .inAddr(inAddr), .inAck(inAck),
    .outReq(outReq), .outAddr(outAddr), .outAck(outAck),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .cfgReady(cfgReady));

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input bit sel, input int idx, input logic [9:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgIdx = 10'(idx); cfgData = data;
    while (!cfgReady) @(negedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (sel) listSh[idx % 64] = data;
    else     mapSh[idx % 1024] = data;
  endtask

  // one input event, bench plays sender and all receivers
  task automatic sendEvent(input int p, input int a, input int stall);
    logic [9:0] ent, exp;
    int ptr, cnt, got, d;
    bit done;
    ent = mapSh[{p[1:0], a[7:0]}];
    ptr = int'(ent[9:4]); cnt = int'(ent[3:0]);
    got = 0; done = 0;
    @(negedge clk);
    addrReg[p] = 8'(a);
    inReq[p] = 1'b1;
    while (!done) begin
      @(negedge clk);
      if (outReq != '0) begin
        d = 0;
        for (int i = 0; i < 4; i++) if (outReq[i]) d = i;
        exp = listSh[(ptr + got) % 64];
        check(got < cnt && d == int'(exp[9:8]) && outAddr[d*8 +: 8] == exp[7:0],
              "R2/R9 destination order and content", {d[1:0], outAddr[d*8 +: 8]}, exp);
        got++;
        repeat (stall) @(negedge clk);
        outAck[d] = 1'b1;
        while (outReq[d]) @(negedge clk);
        outAck[d] = 1'b0;
      end else if (inAck[p]) begin
        check(got == cnt, cnt == 0 ? "R3 zero count drop" : "R4 ack after all destinations",
              got, cnt);
        repeat (3) @(negedge clk);
        check(inAck[p] && outReq == '0, "R8 ack held while request high",
              {inAck, outReq}, {4'(1 << p), 4'h0});
        inReq[p] = 1'b0;
        while (inAck[p]) @(negedge clk);
        done = 1;
      end
    end
  endtask

  initial begin
    int ord [4];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) addrReg[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outReq == '0 && inAck == '0 && cfgReady, "R1 reset state",
          {outReq, inAck, 3'b0, cfgReady}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    check(outReq == '0 && inAck == '0 && cfgReady, "R1 after reset release",
          {outReq, inAck, 3'b0, cfgReady}, 32'h1);

    for (int i = 0; i < 64; i++) cfgWrite(1'b1, i, 10'($urandom));
    for (int i = 0; i < 1024; i++)
      cfgWrite(1'b0, i, {6'($urandom), 4'($urandom % 5)});

    // R3 zero-count entry
    cfgWrite(1'b0, {2'd2, 8'd9}, {6'd3, 4'd0});
    sendEvent(2, 9, 0);
    // R2 single and multi fan-out
    cfgWrite(1'b0, {2'd0, 8'd1}, {6'd20, 4'd1});
    sendEvent(0, 1, 0);
    cfgWrite(1'b0, {2'd3, 8'd77}, {6'd30, 4'd7});
    sendEvent(3, 77, 1);
    // R9 pointer wrap from slot 63 to slot 0
    cfgWrite(1'b0, {2'd3, 8'd255}, {6'd62, 4'd4});
    sendEvent(3, 255, 2);

    // R7 write held off during a stalled fan-out
    cfgWrite(1'b1, 10, {2'd1, 8'hA5});
    cfgWrite(1'b1, 11, {2'd2, 8'h5A});
    cfgWrite(1'b0, {2'd1, 8'd7}, {6'd10, 4'd2});
    fork
      sendEvent(1, 7, 20);
      begin
        repeat (8) @(negedge clk);
        check(!cfgReady && outReq != '0, "R7 busy during fan-out", {outReq, 3'b0, cfgReady}, 32'h0);
        cfgWrite(1'b1, 11, {2'd3, 8'hC3});
      end
    join
    check(listSh[11] == {2'd3, 8'hC3}, "R7 held write landed", listSh[11], {2'd3, 8'hC3});
    sendEvent(1, 7, 0);

    // R6 rotation: serve port 1 alone, then all four together
    for (int i = 0; i < 4; i++) cfgWrite(1'b0, {i[1:0], 8'd5}, 10'd0);
    sendEvent(1, 5, 0);
    ord = '{2, 3, 0, 1};
    @(negedge clk);
    for (int i = 0; i < 4; i++) addrReg[i] = 8'd5;
    inReq = 4'hF;
    for (int n = 0; n < 4; n++) begin
      int g;
      while (inAck == '0) @(negedge clk);
      g = 0;
      for (int i = 0; i < 4; i++) if (inAck[i]) g = i;
      check(g == ord[n], "R6 round-robin order", g, ord[n]);
      inReq[g] = 1'b0;
      while (inAck[g]) @(negedge clk);
    end

    // random traffic
    for (int n = 0; n < 150; n++)
      sendEvent(int'($urandom % 4), int'($urandom % 256), int'($urandom % 4));

    repeat (5) @(negedge clk);
    check(outReq == '0 && inAck == '0 && cfgReady, "R1 quiet at end",
          {outReq, inAck, 3'b0, cfgReady}, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule